// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block sits behind the bit-level front end of an I2C target. It sees whole received bytes and bus conditions (START, repeated START, STOP) as single-cycle strobes. It decides, for each address byte, whether the target acknowledges. It also keeps two flags for the data phase that follows: one says the target has been selected, the other says the controller asked to read. The data phase itself, and sampling of the bus lines, belong to other blocks.

A 16-bit programmed word holds the target address. When its top five bits are `11110`, the word describes a 10-bit address. Otherwise bits [15:9] hold a 7-bit address. A separate enable decides whether the general-call byte 00h is answered. A 10-bit selection is remembered until the next STOP or plain START. During that time the controller can turn the transfer around by sending a repeated START and only the first address byte with the read bit set.

Top module: `i2c_addr_recognizer`

## Requirements
- R1: After reset, `ack_vld`, `ack_out`, `selected` and `read_req` are all 0, and received bytes get no decision until a START or repeated START is seen.
- R2: When `own_word[15:11]` is not `11110`, the first byte after a START is acknowledged if its bits [7:1] equal `own_word[15:9]`. This sets `selected`, and `read_req` takes the byte's bit 0 (1 = read).
- R3: When `own_word[15:11]` is `11110`, the first byte `{11110, own_word[10:9], 0}` is acknowledged without setting `selected`. The next byte is acknowledged when it equals `own_word[7:0]`, and that sets `selected`. `own_word[8]` has no effect.
- R4: After a completed 10-bit selection and a repeated START, the byte `{11110, own_word[10:9], 1}` is acknowledged and sets both `selected` and `read_req`. Without a prior 10-bit selection, the same byte is not acknowledged.
- R5: An address byte of 00h is acknowledged only when `gc_en` is 1. When it is acknowledged, `selected` is set and `read_req` is cleared.
- R6: An address byte of 01h is never acknowledged, even when the programmed 7-bit address is 0.
- R7: A non-matching address byte gets a decision of 0 and clears `selected`. After that, no byte gets a decision until a STOP followed by a new START.
- R8: A STOP clears `selected`, `read_req` and the remembered 10-bit selection.
- R9: A repeated START clears `selected` and `read_req`, unless a 10-bit selection is remembered. In that case both flags are held until the next byte decides them, and a byte that does not match clears them.
- R10: `ack_vld` is high for exactly the one cycle after the `byte_vld` of an address byte, with `ack_out` = 1 for acknowledge. `ack_out` is 0 whenever `ack_vld` is 0. Bytes in the data phase after a selection produce no `ack_vld`.
- R11: Strobes in the same cycle are resolved with STOP first, then START, then repeated START, then the byte. A byte that coincides with any bus condition is discarded and gets no decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| own_word | input | 16 | Programmed address word (mode chosen by bits [15:11]) |
| gc_en | input | 1 | Answer the general-call byte 00h |
| start_det | input | 1 | START seen on an idle bus (one-cycle strobe) |
| rstart_det | input | 1 | Repeated START seen (one-cycle strobe) |
| stop_det | input | 1 | STOP seen (one-cycle strobe) |
| byte_vld | input | 1 | A complete byte has been received (one-cycle strobe) |
| byte_data | input | 8 | The received byte, MSB first on the bus |
| ack_vld | output | 1 | An acknowledge decision is presented this cycle |
| ack_out | output | 1 | 1 = acknowledge the address byte, 0 = stay silent |
| selected | output | 1 | The target has been addressed |
| read_req | output | 1 | The target has been addressed for a read |

## Verification
Two things can land in the same cycle: a byte strobe and a bus-condition strobe (STOP or START). The bench forces this directly. It raises `stop_det` together with a `byte_vld` whose byte matches the programmed address, and checks that no decision appears and that both flags are clear. It then raises `start_det` with a matching byte and checks that this byte is also dropped, while the next lone byte is acknowledged. Random sequences with a fixed seed mix all four strobes freely, so overlaps also occur without being planned, and every step is compared against a reference model in the bench.

// File: rtl/i2c_arec_pkg.sv
// Package: shared widths, codes and types for the address recognizer.
// Assumes the I2C byte is 8 bits and the programmed word is two bytes wide.
package i2c_arec_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int A7_W   = BYTE_W - 1;
    localparam int PFX_W  = 5;
    localparam int HI_W   = A7_W - PFX_W;
    localparam logic [PFX_W-1:0]  PFX10      = 5'b11110;
    localparam logic [BYTE_W-1:0] GC_CODE    = 8'h00;
    localparam logic [BYTE_W-1:0] SBYTE_CODE = 8'h01;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HDR,
        PH_LOW,
        PH_DATA,
        PH_SKIP
    } phase_t;

    typedef struct packed {
        logic gc;
        logic sbyte;
        logic mode10;
        logic hit7;
        logic hdr10;
        logic low10;
        logic rw;
    } match_t;
endpackage

// File: rtl/i2c_arec_cmp.sv
// Module: i2c_arec_cmp
// Compares one received byte against the programmed word. It reports each kind
// of match separately and leaves the decision to the controller.
// Assumes: purely combinational; bit BYTE_W of the word is a don't-care.
module i2c_arec_cmp
    import i2c_arec_pkg::*;
(
    input  logic [WORD_W-1:0] own_word,
    input  logic [BYTE_W-1:0] rx_byte,
    output match_t            m
);
    logic unused_bit8;
    assign unused_bit8 = own_word[BYTE_W];

    // Bitwise comparisons against each field of the programmed word
    always_comb begin
        m.mode10 = (own_word[WORD_W-1 -: PFX_W] == PFX10);
        m.hit7   = (rx_byte[BYTE_W-1:1] == own_word[WORD_W-1 -: A7_W]);
        m.hdr10  = (rx_byte[BYTE_W-1:1] == {PFX10, own_word[BYTE_W+HI_W -: HI_W]});
        m.low10  = (rx_byte == own_word[BYTE_W-1:0]);
        m.gc     = (rx_byte == GC_CODE);
        m.sbyte  = (rx_byte == SBYTE_CODE);
        m.rw     = rx_byte[0];
    end
endmodule

// File: rtl/i2c_arec_evt.sv
// Module: i2c_arec_evt
// Resolves strobes that arrive in the same cycle into one event. The order is
// STOP, START, repeated START, byte.
// Assumes: every input is a one-cycle strobe from the bit-level front end.
module i2c_arec_evt (
    input  logic start_det,
    input  logic rstart_det,
    input  logic stop_det,
    input  logic byte_vld,
    output logic ev_stop,
    output logic ev_start,
    output logic ev_rep,
    output logic ev_byte
);
    // Fixed-priority masking of lower events
    always_comb begin
        ev_stop  = stop_det;
        ev_start = start_det & ~stop_det;
        ev_rep   = rstart_det & ~stop_det & ~start_det;
        ev_byte  = byte_vld & ~stop_det & ~start_det & ~rstart_det;
    end
endmodule

// File: rtl/i2c_arec_ctl.sv
// Module: i2c_arec_ctl
// Phase tracker and decision register. It follows the address phase after each
// START, registers one acknowledge decision per address byte, and keeps the
// selected, read and remembered-10-bit flags.
// Assumes: at most one event per cycle (see i2c_arec_evt).
module i2c_arec_ctl
    import i2c_arec_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ev_stop,
    input  logic   ev_start,
    input  logic   ev_rep,
    input  logic   ev_byte,
    input  logic   gc_en,
    input  match_t m,
    output logic   ack_vld,
    output logic   ack_out,
    output logic   selected,
    output logic   read_req
);
    phase_t phase, d_ph;
    logic   armed;
    logic   d_vld, d_ack, d_sel, d_rd, d_arm;

    // Decision for a byte received in the current phase
    always_comb begin
        d_vld = (phase == PH_HDR) || (phase == PH_LOW);
        d_ack = 1'b0;
        d_sel = 1'b0;
        d_rd  = 1'b0;
        d_arm = 1'b0;
        d_ph  = PH_SKIP;
        case (phase)
            PH_HDR: begin
                if (m.gc) begin
                    if (gc_en) begin
                        d_ack = 1'b1;
                        d_sel = 1'b1;
                        d_ph  = PH_DATA;
                    end
                end else if (m.sbyte) begin
                    d_ack = 1'b0;
                end else if (!m.mode10) begin
                    if (m.hit7) begin
                        d_ack = 1'b1;
                        d_sel = 1'b1;
                        d_rd  = m.rw;
                        d_ph  = PH_DATA;
                    end
                end else if (m.hdr10 && !m.rw) begin
                    d_ack = 1'b1;
                    d_ph  = PH_LOW;
                end else if (m.hdr10 && armed) begin
                    d_ack = 1'b1;
                    d_sel = 1'b1;
                    d_rd  = 1'b1;
                    d_arm = 1'b1;
                    d_ph  = PH_DATA;
                end
            end
            PH_LOW: begin
                if (m.low10) begin
                    d_ack = 1'b1;
                    d_sel = 1'b1;
                    d_arm = 1'b1;
                    d_ph  = PH_DATA;
                end
            end
            default: begin
                d_sel = selected;
                d_rd  = read_req;
                d_arm = armed;
                d_ph  = phase;
            end
        endcase
    end

    // State, flag and decision registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            armed    <= 1'b0;
            selected <= 1'b0;
            read_req <= 1'b0;
            ack_vld  <= 1'b0;
            ack_out  <= 1'b0;
        end else begin
            ack_vld <= 1'b0;
            ack_out <= 1'b0;
            if (ev_stop || ev_start) begin
                phase    <= ev_stop ? PH_IDLE : PH_HDR;
                armed    <= 1'b0;
                selected <= 1'b0;
                read_req <= 1'b0;
            end else if (ev_rep) begin
                phase <= PH_HDR;
                if (!armed) begin
                    selected <= 1'b0;
                    read_req <= 1'b0;
                end
            end else if (ev_byte) begin
                ack_vld  <= d_vld;
                ack_out  <= d_vld & d_ack;
                selected <= d_sel;
                read_req <= d_rd;
                armed    <= d_arm;
                phase    <= d_ph;
            end
        end
    end
endmodule

// File: rtl/i2c_addr_recognizer.sv
// Module: i2c_addr_recognizer (top)
// Decides whether an I2C target acknowledges each address byte. It supports
// 7-bit and 10-bit addressing and the general call, and tracks the selected
// and read-request flags.
// Assumes: byte and bus-condition strobes come from a bit-level front end and
// last one cycle each; the decision is used before the ninth clock.
module i2c_addr_recognizer
    import i2c_arec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] own_word,
    input  logic              gc_en,
    input  logic              start_det,
    input  logic              rstart_det,
    input  logic              stop_det,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              ack_vld,
    output logic              ack_out,
    output logic              selected,
    output logic              read_req
);
    logic   ev_stop, ev_start, ev_rep, ev_byte;
    match_t m;

    i2c_arec_evt u_evt (
        .start_det (start_det),
        .rstart_det(rstart_det),
        .stop_det  (stop_det),
        .byte_vld  (byte_vld),
        .ev_stop   (ev_stop),
        .ev_start  (ev_start),
        .ev_rep    (ev_rep),
        .ev_byte   (ev_byte)
    );

    i2c_arec_cmp u_cmp (
        .own_word(own_word),
        .rx_byte (byte_data),
        .m       (m)
    );

    i2c_arec_ctl u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_stop (ev_stop),
        .ev_start(ev_start),
        .ev_rep  (ev_rep),
        .ev_byte (ev_byte),
        .gc_en   (gc_en),
        .m       (m),
        .ack_vld (ack_vld),
        .ack_out (ack_out),
        .selected(selected),
        .read_req(read_req)
    );
endmodule

// File: rtl/i2c_arec_chk.sv
// Module: i2c_arec_chk
// Temporal checks on the recognizer's ports, attached through bind.
// Assumes: synchronous active-low reset; checks are disabled while it is low.
module i2c_arec_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       gc_en,
    input logic       start_det,
    input logic       rstart_det,
    input logic       stop_det,
    input logic       byte_vld,
    input logic [7:0] byte_data,
    input logic       ack_vld,
    input logic       ack_out,
    input logic       selected,
    input logic       read_req
);
    assert_ack_after_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld |-> $past(byte_vld));

    assert_ack_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_vld |-> !ack_out);

    assert_read_needs_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        read_req |-> selected);

    assert_stop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!selected && !read_req));

    assert_sbyte_nack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && byte_data == 8'h01) |=> !ack_out);

    assert_gc_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && byte_data == 8'h00 && !gc_en) |=> !ack_out);

    assert_cond_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det || start_det || rstart_det) |=> !ack_vld);
endmodule

bind i2c_addr_recognizer i2c_arec_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gc_en     (gc_en),
    .start_det (start_det),
    .rstart_det(rstart_det),
    .stop_det  (stop_det),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .ack_vld   (ack_vld),
    .ack_out   (ack_out),
    .selected  (selected),
    .read_req  (read_req)
);

// File: tb/tb_i2c_addr_recognizer.sv
// Bench: directed corner cases, then seeded random strobe sequences, all
// compared against a reference model written from the requirements.
module tb_i2c_addr_recognizer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] own_word = 16'h0000;
    logic        gc_en = 1'b0;
    logic        start_det = 1'b0, rstart_det = 1'b0, stop_det = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        ack_vld, ack_out, selected, read_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // model state: 0 idle, 1 header, 2 low byte, 3 data, 4 skip
    int m_ph = 0;
    bit m_arm = 0, m_sel = 0, m_rd = 0;
    bit e_av = 0, e_ack = 0;

    always #10 clk = ~clk;

    i2c_addr_recognizer dut (
        .clk(clk), .rst_n(rst_n), .own_word(own_word), .gc_en(gc_en),
        .start_det(start_det), .rstart_det(rstart_det), .stop_det(stop_det),
        .byte_vld(byte_vld), .byte_data(byte_data),
        .ack_vld(ack_vld), .ack_out(ack_out), .selected(selected), .read_req(read_req)
    );

    task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got {vld,ack,sel,rd}=%b expected %b", tag, got, exp);
        end
    endtask

    function automatic bit is_mode10(input logic [15:0] w);
        return w[15:11] == 5'b11110;
    endfunction

    // Reference model update for a byte strobe
    task automatic model_byte(input logic [7:0] b);
        bit hdr;
        hdr = (b[7:1] == {5'b11110, own_word[10:9]});
        e_av = 0; e_ack = 0;
        if (m_ph == 1 || m_ph == 2) begin
            e_av = 1;
            if (m_ph == 2) begin
                if (b == own_word[7:0]) begin e_ack = 1; m_sel = 1; m_rd = 0; m_arm = 1; m_ph = 3; end
            end else if (b == 8'h00) begin
                if (gc_en) begin e_ack = 1; m_sel = 1; m_rd = 0; m_arm = 0; m_ph = 3; end
            end else if (b == 8'h01) begin
                e_ack = 0;
            end else if (!is_mode10(own_word)) begin
                if (b[7:1] == own_word[15:9]) begin e_ack = 1; m_sel = 1; m_rd = b[0]; m_arm = 0; m_ph = 3; end
            end else if (hdr && !b[0]) begin
                e_ack = 1; m_sel = 0; m_rd = 0; m_arm = 0; m_ph = 2;
            end else if (hdr && m_arm) begin
                e_ack = 1; m_sel = 1; m_rd = 1; m_ph = 3;
            end
            if (!e_ack) begin m_sel = 0; m_rd = 0; m_arm = 0; m_ph = 4; end
        end
    endtask

    // Drive one cycle of strobes, update model, check all outputs
    task automatic step(input string tag, input bit st, input bit rs, input bit sp,
                        input bit bv, input logic [7:0] b);
        @(negedge clk);
        start_det = st; rstart_det = rs; stop_det = sp; byte_vld = bv; byte_data = b;
        e_av = 0; e_ack = 0;
        if (sp) begin m_ph = 0; m_arm = 0; m_sel = 0; m_rd = 0; end
        else if (st) begin m_ph = 1; m_arm = 0; m_sel = 0; m_rd = 0; end
        else if (rs) begin m_ph = 1; if (!m_arm) begin m_sel = 0; m_rd = 0; end end
        else if (bv) model_byte(b);
        @(negedge clk);
        start_det = 0; rstart_det = 0; stop_det = 0; byte_vld = 0;
        chk(tag, {ack_vld, ack_out, selected, read_req}, {e_av, e_ack, m_sel, m_rd});
    endtask

    task automatic start_(input string t);  step(t, 1, 0, 0, 0, 8'h00); endtask
    task automatic rstart_(input string t); step(t, 0, 1, 0, 0, 8'h00); endtask
    task automatic stop_(input string t);   step(t, 0, 0, 1, 0, 8'h00); endtask
    task automatic byte_(input string t, input logic [7:0] b); step(t, 0, 0, 0, 1, b); endtask

    function automatic logic [15:0] rand_word();
        logic [15:0] w;
        w = 16'($urandom);
        if ($urandom % 2) w[15:11] = 5'b11110;
        else if (w[15:11] == 5'b11110) w[15] = 1'b0;
        return w;
    endfunction

    function automatic logic [7:0] rand_byte();
        case ($urandom % 6)
            0: return 8'h00;
            1: return 8'h01;
            2: return {own_word[15:9], 1'($urandom)};
            3: return {5'b11110, own_word[10:9], 1'($urandom)};
            4: return own_word[7:0];
            default: return 8'($urandom);
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 outputs in reset", {ack_vld, ack_out, selected, read_req}, 4'b0000);
        rst_n = 1'b1;
        own_word = 16'h14A5;                 // 7-bit address 0x0A, low bits junk
        byte_("R1 byte before any START gets no decision", 8'h14);

        // 7-bit write and read
        start_("R2 start");
        byte_("R2 7-bit write match", 8'h14);
        byte_("R10 data-phase byte has no decision", 8'h55);
        stop_("R8 stop clears");
        start_("R2 start");
        byte_("R2 7-bit read match", 8'h15);
        rstart_("R9 rstart without 10-bit clears flags");
        stop_("R8 stop");

        // mismatch and skip until STOP
        start_("R7 start");
        byte_("R7 mismatch nacked", 8'h16);
        byte_("R7 later matching byte ignored", 8'h14);
        stop_("R7 stop");
        start_("R7 start");
        byte_("R7 recognition resumes", 8'h14);
        stop_("R7 stop");

        // general call
        gc_en = 1'b0;
        start_("R5 start");
        byte_("R5 general call disabled", 8'h00);
        stop_("R5 stop");
        gc_en = 1'b1;
        start_("R5 start");
        byte_("R5 general call enabled", 8'h00);
        stop_("R5 stop");

        // start byte against address 0
        own_word = 16'h0000;
        start_("R6 start");
        byte_("R6 start byte never acked", 8'h01);
        stop_("R6 stop");

        // 10-bit write then turn-around read
        own_word = 16'hF55C;
        start_("R3 start");
        byte_("R3 10-bit header", 8'hF4);
        byte_("R3 10-bit low byte", 8'h5C);
        rstart_("R9 rstart holds 10-bit selection");
        byte_("R4 10-bit read header", 8'hF5);
        stop_("R8 stop clears");
        start_("R8 start");
        byte_("R8 memory gone: read header nacked", 8'hF5);
        stop_("R4 stop");
        start_("R4 start");
        byte_("R4 read header without selection", 8'hF5);
        stop_("R4 stop");

        // bit 8 ignored; low byte mismatch
        own_word = 16'hF45C;
        start_("R3 start");
        byte_("R3 header with bit8 clear", 8'hF4);
        byte_("R3 low byte with bit8 clear", 8'h5C);
        rstart_("R9 rstart");
        byte_("R9 other address after rstart clears", 8'h14);
        stop_("R9 stop");
        start_("R3 start");
        byte_("R3 header", 8'hF4);
        byte_("R3 low byte mismatch", 8'h5D);
        stop_("R3 stop");

        // same-cycle overlaps
        own_word = 16'h14A5;
        start_("R11 start");
        step("R11 stop with byte: byte dropped", 0, 0, 1, 1, 8'h14);
        step("R11 start with byte: byte dropped", 1, 0, 0, 1, 8'h14);
        byte_("R11 next byte acked", 8'h14);
        step("R11 rstart with byte", 0, 1, 0, 1, 8'h15);
        stop_("R11 stop");

        // random sequences
        for (int i = 0; i < 600; i++) begin
            int r;
            r = $urandom % 20;
            if (r < 3) start_("R2 rnd start");
            else if (r < 6) rstart_("R9 rnd rstart");
            else if (r < 8) begin
                stop_("R8 rnd stop");
                own_word = rand_word();
                gc_en = 1'($urandom);
            end else if (r < 9) step("R11 rnd overlap", 1'($urandom), 1'($urandom), 1'($urandom), 1, rand_byte());
            else byte_("R10 rnd byte", rand_byte());
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule